// File: doc/BRIEF.md
# Packet Setup and Payload Ingest

This block sits at the front of a transmit path. It takes one 64-bit setup word for each packet on a configuration stream, then takes the packet's payload one byte at a time on a separate byte stream. The setup word carries the byte count of the packet. The block forwards exactly that many payload bytes to a downstream byte consumer. Each forwarded byte travels with the latched setup word and with a flag that marks the final counted byte. After the last byte the block goes back to waiting for the next setup word.

The two streams are strictly sequenced. While the block waits for a setup word, it refuses payload. While a packet is in progress, it refuses setup words. The upstream source marks its final payload byte with tlast. The block compares that marker with its own count and records any disagreement in a sticky error flag. A disagreement never changes the byte count; the configured length alone decides when the packet ends.

Top module: `pkt_ingest`

## Requirements
- R1: After a synchronous active-low reset, the block is in its waiting state: `cfg_tready`=1, `pay_tready`=0, `out_valid`=0, `len_err`=0.
- R2: `cfg_tready` is high only in the waiting state, and `cfg_tready` and `pay_tready` are never high together. A payload beat offered while the block waits is not taken and is not forwarded.
- R3: The packet length is bits [15:0] of the setup word. After a setup word of length N>0 is accepted, exactly N payload bytes are forwarded. `cfg_tready` returns to 1 in the cycle after the N-th byte is taken.
- R4: A setup word with length 0 leaves the block waiting. In the next cycle `cfg_tready`=1 and `pay_tready`=0.
- R5: `out_cfg` holds the most recently accepted setup word for every byte of the packet. It changes only when a new setup word is accepted.
- R6: During a packet, `pay_tready` equals `out_ready`. A byte offered while `out_ready`=0 is not consumed and is not counted.
- R7: `out_last` is 1 exactly on the N-th counted byte of the packet, regardless of `pay_tlast`.
- R8: A `pay_tlast` of 1 on a byte before the N-th sets `len_err`, and the block still forwards all N bytes.
- R9: A `pay_tlast` of 0 on the N-th byte sets `len_err`, and the block still returns to waiting.
- R10: `len_err` stays at 1 across later packets until reset, and reset clears it.
- R11: `out_valid` is 1 only during a packet, when `pay_tvalid`=1. `out_data` then equals `pay_tdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tvalid | input | 1 | Setup stream valid |
| cfg_tdata | input | 64 | Setup word; bits [15:0] hold the byte length |
| cfg_tready | output | 1 | Setup stream ready (waiting state only) |
| pay_tvalid | input | 1 | Payload stream valid |
| pay_tdata | input | 8 | Payload byte |
| pay_tlast | input | 1 | Upstream end-of-packet marker |
| pay_tready | output | 1 | Payload stream ready |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Final counted byte of the packet |
| out_cfg | output | 64 | Latched setup word for the packet |
| out_ready | input | 1 | Downstream consumer ready |
| len_err | output | 1 | Sticky tlast/length mismatch flag |

## Verification
Two events can fall in the same cycle: the final counted byte being taken, and the next setup word being offered. The bench holds `cfg_tvalid` high, with a fresh setup word, during the last byte of a packet. It judges that `cfg_tready` stays low in that cycle and rises one cycle later. It then checks that the first byte of the next packet carries the new word on `out_cfg`. A second case also shares a cycle: the length check firing on that same final byte when tlast is missing. The bench judges it by checking that `len_err` and the return to waiting both appear at the next sample.

// File: rtl/pkt_ingest_pkg.sv
package pkt_ingest_pkg;
  localparam int CFG_W  = 64;
  localparam int LEN_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {ST_WAIT_CFG = 1'b0, ST_PAYLOAD = 1'b1} seq_state_t;

  function automatic logic [LEN_W-1:0] cfg_length(input logic [CFG_W-1:0] word);
    return word[LEN_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] count_down(input logic [LEN_W-1:0] cnt);
    return cnt - LEN_W'(1);
  endfunction

  function automatic logic is_final(input logic [LEN_W-1:0] cnt);
    return cnt == LEN_W'(1);
  endfunction
endpackage

// File: rtl/ingest_seq.sv
module ingest_seq
  import pkt_ingest_pkg::*;
#(
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fire,
  input  logic [LW-1:0] cfg_len,
  input  logic          byte_fire,
  output logic          in_payload,
  output logic          final_slot
);
  seq_state_t    state_q;
  logic [LW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT_CFG;
      remain_q <= '0;
    end else begin
      case (state_q)
        ST_WAIT_CFG: begin
          if (cfg_fire && cfg_len != '0) begin
            state_q  <= ST_PAYLOAD;
            remain_q <= cfg_len;
          end
        end
        ST_PAYLOAD: begin
          if (byte_fire) begin
            remain_q <= count_down(remain_q);
            if (is_final(remain_q)) state_q <= ST_WAIT_CFG;
          end
        end
        default: state_q <= ST_WAIT_CFG;
      endcase
    end
  end

  assign in_payload = (state_q == ST_PAYLOAD);
  assign final_slot = in_payload && is_final(remain_q);
endmodule

// File: rtl/ingest_cfg_hold.sv
module ingest_cfg_hold #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_fire,
  input  logic [W-1:0] cfg_word,
  output logic [W-1:0] held_cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)        held_cfg <= '0;
    else if (cfg_fire) held_cfg <= cfg_word;
  end
endmodule

// File: rtl/ingest_len_check.sv
module ingest_len_check (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_fire,
  input  logic marker,
  input  logic final_slot,
  output logic mismatch,
  output logic err_q
);
  assign mismatch = byte_fire && (marker != final_slot);

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (mismatch) err_q <= 1'b1;
  end
endmodule

// File: rtl/pkt_ingest.sv
module pkt_ingest
  import pkt_ingest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tvalid,
  input  logic [CFG_W-1:0]  cfg_tdata,
  output logic              cfg_tready,
  input  logic              pay_tvalid,
  input  logic [BYTE_W-1:0] pay_tdata,
  input  logic              pay_tlast,
  output logic              pay_tready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic [CFG_W-1:0]  out_cfg,
  input  logic              out_ready,
  output logic              len_err
);
  logic cfg_fire;
  logic byte_fire;
  logic in_payload;
  logic final_slot;
  logic mismatch;

  assign cfg_fire  = cfg_tvalid && cfg_tready;
  assign byte_fire = pay_tvalid && pay_tready;

  ingest_seq #(.LW(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fire   (cfg_fire),
    .cfg_len    (cfg_length(cfg_tdata)),
    .byte_fire  (byte_fire),
    .in_payload (in_payload),
    .final_slot (final_slot)
  );

  ingest_cfg_hold #(.W(CFG_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_fire (cfg_fire),
    .cfg_word (cfg_tdata),
    .held_cfg (out_cfg)
  );

  ingest_len_check u_chk_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_fire  (byte_fire),
    .marker     (pay_tlast),
    .final_slot (final_slot),
    .mismatch   (mismatch),
    .err_q      (len_err)
  );

  assign cfg_tready = !in_payload;
  assign pay_tready = in_payload && out_ready;
  assign out_valid  = in_payload && pay_tvalid;
  assign out_data   = pay_tdata;
  assign out_last   = final_slot;
endmodule

// File: rtl/pkt_ingest_chk.sv
module pkt_ingest_chk
  import pkt_ingest_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fire,
  input logic             byte_fire,
  input logic [CFG_W-1:0] cfg_tdata,
  input logic             cfg_tready,
  input logic             pay_tready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [CFG_W-1:0] out_cfg,
  input logic             mismatch,
  input logic             len_err
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_tready && pay_tready)); // R2
  AST_NO_OUT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tready |-> !out_valid); // R11
  AST_ZERO_LEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fire && cfg_tdata[LEN_W-1:0] == '0) |=> cfg_tready); // R4
  AST_NONZERO_LEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fire && cfg_tdata[LEN_W-1:0] != '0) |=> !cfg_tready); // R3
  AST_FINAL_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && out_last) |=> cfg_tready); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fire |=> $stable(out_cfg)); // R5
  AST_PAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pay_tready |-> out_ready); // R6
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> len_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err); // R10
endmodule

bind pkt_ingest pkt_ingest_chk u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_fire   (cfg_fire),
  .byte_fire  (byte_fire),
  .cfg_tdata  (cfg_tdata),
  .cfg_tready (cfg_tready),
  .pay_tready (pay_tready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .out_cfg    (out_cfg),
  .mismatch   (mismatch),
  .len_err    (len_err)
);

// File: tb/tb_pkt_ingest.sv
`timescale 1ns/1ps
module tb_pkt_ingest;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tvalid = 1'b0;
  logic [63:0] cfg_tdata = '0;
  logic        cfg_tready;
  logic        pay_tvalid = 1'b0;
  logic [7:0]  pay_tdata = '0;
  logic        pay_tlast = 1'b0;
  logic        pay_tready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic [63:0] out_cfg;
  logic        out_ready = 1'b1;
  logic        len_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pkt_ingest dut (.*);

  // {len[15:0], tag[7:0], mode[7:0], idx[7:0]}; mode 0 = tlast on final, 1 = tlast at idx only, 2 = no tlast
  localparam logic [39:0] VEC [6] = '{
    {16'd1, 8'hA1, 8'd0, 8'd0},
    {16'd3, 8'hB2, 8'd0, 8'd0},
    {16'd5, 8'hC3, 8'd0, 8'd0},
    {16'd4, 8'hD4, 8'd1, 8'd1},
    {16'd3, 8'hE5, 8'd2, 8'd0},
    {16'd2, 8'hF6, 8'd1, 8'd0}
  };

  function automatic logic [63:0] mk_cfg(input logic [7:0] tag, input logic [15:0] len);
    return {tag, 40'hA5A50F0F33, len};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_tvalid = 1'b0; pay_tvalid = 1'b0; pay_tlast = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_beat(input logic [63:0] word);
    @(negedge clk);
    cfg_tvalid = 1'b1; cfg_tdata = word;
    #1 chk(cfg_tready == 1'b1, "R2 cfg_tready in waiting", 64'(cfg_tready), 64'd1);
    @(posedge clk);
    #1 cfg_tvalid = 1'b0;
  endtask

  task automatic pay_beat(input logic [7:0] d, input logic lst, input logic exp_last, input logic [63:0] exp_cfg);
    @(negedge clk);
    pay_tvalid = 1'b1; pay_tdata = d; pay_tlast = lst;
    #1;
    chk(out_valid == 1'b1 && out_data == d, "R11 forwarded byte", {out_valid, out_data}, {1'b1, d});
    chk(out_last == exp_last, "R7 out_last", 64'(out_last), 64'(exp_last));
    chk(out_cfg == exp_cfg, "R5 out_cfg", out_cfg, exp_cfg);
    @(posedge clk);
    #1 pay_tvalid = 1'b0; pay_tlast = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk(cfg_tready == 1 && pay_tready == 0 && out_valid == 0 && len_err == 0, "R1 reset state",
        {cfg_tready, pay_tready, out_valid, len_err}, 4'b1000);

    // table walk
    foreach (VEC[v]) begin
      logic [15:0] len;
      logic [7:0]  tag, mode, idx;
      logic [63:0] w;
      {len, tag, mode, idx} = VEC[v];
      w = mk_cfg(tag, len);
      do_reset();
      cfg_beat(w);
      for (int i = 0; i < int'(len); i++) begin
        logic lst;
        lst = (mode == 0) ? (i == int'(len) - 1) : (mode == 1) ? (i == int'(idx)) : 1'b0;
        pay_beat(tag + 8'(i), lst, i == int'(len) - 1, w);
      end
      @(negedge clk); #1;
      chk(cfg_tready == 1'b1, "R3 back to waiting after N bytes", 64'(cfg_tready), 64'd1);
      if (mode == 1) chk(len_err == 1'b1, "R8 early tlast flagged", 64'(len_err), 64'd1);
      else if (mode == 2) chk(len_err == 1'b1, "R9 missing tlast flagged", 64'(len_err), 64'd1);
      else chk(len_err == 1'b0, "R3 clean packet no error", 64'(len_err), 64'd0);
    end

    // R10: sticky across a clean packet, then cleared by reset
    cfg_beat(mk_cfg(8'h11, 16'd1));
    pay_beat(8'h5A, 1'b1, 1'b1, mk_cfg(8'h11, 16'd1));
    @(negedge clk); #1;
    chk(len_err == 1'b1, "R10 err sticky", 64'(len_err), 64'd1);
    do_reset(); #1;
    chk(len_err == 1'b0, "R10 reset clears err", 64'(len_err), 64'd0);

    // R2: payload in waiting state is ignored
    @(negedge clk);
    pay_tvalid = 1'b1; pay_tdata = 8'hEE; pay_tlast = 1'b1;
    #1;
    chk(pay_tready == 1'b0 && out_valid == 1'b0, "R2 payload refused while waiting",
        {pay_tready, out_valid}, 2'b00);
    @(posedge clk); #1 pay_tvalid = 1'b0; pay_tlast = 1'b0;
    cfg_beat(mk_cfg(8'h22, 16'd2));
    pay_beat(8'h01, 1'b0, 1'b0, mk_cfg(8'h22, 16'd2));
    pay_beat(8'h02, 1'b1, 1'b1, mk_cfg(8'h22, 16'd2));
    @(negedge clk); #1;
    chk(len_err == 1'b0 && cfg_tready == 1'b1, "R2 stale beat not counted",
        {len_err, cfg_tready}, 2'b01);

    // R4: zero length
    cfg_beat(mk_cfg(8'h33, 16'd0));
    @(negedge clk); #1;
    chk(cfg_tready == 1'b1 && pay_tready == 1'b0, "R4 zero length stays waiting",
        {cfg_tready, pay_tready}, 2'b10);
    chk(out_cfg == mk_cfg(8'h33, 16'd0), "R5 zero-length word latched", out_cfg, mk_cfg(8'h33, 16'd0));

    // R6: backpressure
    cfg_beat(mk_cfg(8'h44, 16'd2));
    @(negedge clk);
    out_ready = 1'b0; pay_tvalid = 1'b1; pay_tdata = 8'h77; pay_tlast = 1'b0;
    #1 chk(pay_tready == 1'b0, "R6 stall drops ready", 64'(pay_tready), 64'd0);
    @(negedge clk); #1;
    chk(pay_tready == 1'b0 && out_last == 1'b0, "R6 stalled byte not counted",
        {pay_tready, out_last}, 2'b00);
    out_ready = 1'b1;
    #1 chk(pay_tready == 1'b1, "R6 ready follows out_ready", 64'(pay_tready), 64'd1);
    @(posedge clk); #1 pay_tvalid = 1'b0;
    pay_beat(8'h78, 1'b1, 1'b1, mk_cfg(8'h44, 16'd2));
    @(negedge clk); #1;
    chk(cfg_tready == 1'b1 && len_err == 1'b0, "R6 packet completes after stall",
        {cfg_tready, len_err}, 2'b10);

    // final byte and next setup word in the same cycle
    cfg_beat(mk_cfg(8'h55, 16'd1));
    @(negedge clk);
    pay_tvalid = 1'b1; pay_tdata = 8'h99; pay_tlast = 1'b1;
    cfg_tvalid = 1'b1; cfg_tdata = mk_cfg(8'h66, 16'd1);
    #1 chk(cfg_tready == 1'b0 && out_last == 1'b1, "R3 setup held off on final byte",
           {cfg_tready, out_last}, 2'b01);
    @(posedge clk); #1 pay_tvalid = 1'b0; pay_tlast = 1'b0;
    @(negedge clk); #1;
    chk(cfg_tready == 1'b1 && out_cfg == mk_cfg(8'h55, 16'd1), "R5 old word until accept",
        out_cfg, mk_cfg(8'h55, 16'd1));
    @(posedge clk); #1 cfg_tvalid = 1'b0;
    pay_beat(8'h9A, 1'b1, 1'b1, mk_cfg(8'h66, 16'd1));
    @(negedge clk); #1;
    chk(cfg_tready == 1'b1 && len_err == 1'b0, "R3 back-to-back packets",
        {cfg_tready, len_err}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule